// File: doc/BRIEF.md
# Serial Management Register Slave

This block is the device side of a two-wire management port: a clock line driven by a remote management master and a bidirectional data line. Bits are taken from the data line on each rising edge of the management clock. A bit that the block drives changes just after a rising edge, so the master samples it on the next one. Each frame addresses one device and one of eleven 16-bit registers, and then either writes that register or reads it back. Five registers hold configuration words that leave the block on a parallel bus. The others report identifier constants, live status, latched status changes, an interrupt mask and the device address.

The device address comes from five strap inputs, which are sampled for as long as reset is held. An active-low, open-drain interrupt is modelled as a "pull low" enable. It is raised whenever a status input bit that the mask enables changes value. It stays raised until the change-latch register has been read and every bit it reported has been cleared. The management clock and data are oversampled by the block's own clock through synchronizers. There is no stream interface and therefore no back-pressure: the master paces every bit with the management clock.

Top module: `mdio_mgmt_slave`

## Requirements
- R1: The device address is taken from `strap_addr` while `rst_n` is low and then held. Later changes of the strap pins have no effect. Register 10 reads back the latched address in bits 4:0. A frame that carries any other device address is ignored: nothing is written and the data line is never driven.
- R2: A frame is accepted only after at least 32 consecutive ones. A frame preceded by 31 ones is ignored.
- R3: The frame layout is preamble, start `01`, a 2-bit opcode (`10` read, `01` write), a 5-bit device address, a 5-bit register address, two turnaround bits and 16 data bits, all MSB first. On a read, the block leaves the line released during the first turnaround bit, drives 0 during the second, and then drives the 16 data bits MSB first. It releases the line after the last data bit.
- R4: Writes update registers 0 to 4 and register 9. Register `k` for `k` in 0..4 appears on `cfg_words[16k+15:16k]`. Writes to read-only registers 5, 6, 7, 8 and 10 change nothing.
- R5: Register addresses 11 to 31 are unimplemented. A read of one never drives the line, and a write to one changes nothing.
- R6: Register 5 reads `ID_HI` and register 6 reads `ID_LO`. Register 7 reads `status_in` in its low `STAT_W` bits, with zeros above.
- R7: When status bit `i` changes and mask bit `i` (register 9) is 1, bit `i` of the change latch (register 8) is set. It stays set after the status returns to its old value.
- R8: `irq_drive_low` is 1 while any change-latch bit is set. A read of register 8 returns the latch and clears exactly the bits it returned. Once every set bit has been read, `irq_drive_low` returns to 0.
- R9: The mask resets to 0xFFFF. A status bit whose mask bit is 0 sets no latch bit and raises no interrupt.
- R10: A frame whose opcode is `00` or `11` is ignored: no register changes and the line is never driven.
- R11: After reset the line is released, `irq_drive_low` is 0 and `cfg_words` equals `CFG_RST`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; oversamples the management port |
| rst_n | input | 1 | Synchronous active-low reset; strap sampling window |
| strap_addr | input | 5 | Device address strap pins |
| mdc | input | 1 | Management clock from the master |
| mdio_in | input | 1 | Resolved level of the management data line |
| mdio_out | output | 1 | Value driven onto the data line when enabled |
| mdio_oe | output | 1 | 1 = block drives the data line |
| status_in | input | STAT_W | Monitored status bits, synchronous to `clk` |
| irq_drive_low | output | 1 | 1 = pull the open-drain interrupt line low |
| cfg_words | output | 80 | Configuration registers 0..4, word k at bits 16k+15:16k |

## Verification
Frames are tried with matching and non-matching device addresses, so that an accepted frame can be told apart from a merely well-formed one. They are also tried with preambles of 32 and 31 ones, which separates a counted preamble from a loosely detected one. Legal and illegal opcodes, together with implemented, read-only and unimplemented register addresses, show whether the write enable and the read drive are gated by every header field. Status toggles under full and partial masks, some of them returned to their old value before the latch is read, show that change tracking is sticky, masked and cleared only by the read that reported it. A seeded random mix of frames and status changes is compared against a bench model of the register file.

// File: rtl/mdio_slv_pkg.sv
package mdio_slv_pkg;

  localparam int REG_W     = 16;
  localparam int CFG_WORDS = 5;

  // register map
  localparam logic [4:0] RA_ID_HI  = 5'd5;
  localparam logic [4:0] RA_ID_LO  = 5'd6;
  localparam logic [4:0] RA_STAT   = 5'd7;
  localparam logic [4:0] RA_CHG    = 5'd8;
  localparam logic [4:0] RA_MASK   = 5'd9;
  localparam logic [4:0] RA_ADDR   = 5'd10;
  localparam logic [4:0] RA_COUNT  = 5'd11;

  // bit positions inside the frame body (after the start pair)
  localparam logic [4:0] FP_REG_LAST = 5'd11;
  localparam logic [4:0] FP_TA1      = 5'd12;
  localparam logic [4:0] FP_TA2      = 5'd13;
  localparam logic [4:0] FP_DATA_LST = 5'd28;
  localparam logic [4:0] FP_LAST     = 5'd29;

  localparam logic [1:0] OP_RD = 2'b10;
  localparam logic [1:0] OP_WR = 2'b01;

  typedef enum logic [1:0] {
    PH_HUNT,
    PH_START,
    PH_BODY
  } phase_t;

  typedef struct packed {
    logic [1:0] op;
    logic [4:0] phy;
    logic [4:0] ra;
  } hdr_t;

endpackage

// File: rtl/mdio_sync.sv
module mdio_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc,
  input  logic mdio_in,
  output logic bit_rise,
  output logic bit_val
);

  logic [STAGES-1:0] mdc_p;
  logic [STAGES-1:0] dio_p;
  logic              mdc_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mdc_p    <= '0;
      dio_p    <= '1;
      mdc_last <= 1'b0;
    end else begin
      mdc_p    <= {mdc_p[STAGES-2:0], mdc};
      dio_p    <= {dio_p[STAGES-2:0], mdio_in};
      mdc_last <= mdc_p[STAGES-1];
    end
  end

  assign bit_rise = mdc_p[STAGES-1] & ~mdc_last;
  assign bit_val  = dio_p[STAGES-1];

endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_slv_pkg::*;
#(
  parameter int PRE_LEN = 32,
  localparam int PC_W   = $clog2(PRE_LEN + 1)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bit_rise,
  input  logic        bit_in,
  input  logic [4:0]  my_addr,
  input  logic [15:0] rd_data,
  output logic        rd_req,
  output logic        wr_en,
  output logic [4:0]  reg_addr,
  output logic [15:0] wr_data,
  output logic        drv_oe,
  output logic        drv_bit
);

  localparam logic [PC_W-1:0] PRE_FULL = PC_W'(PRE_LEN);

  phase_t          phase;
  logic [PC_W-1:0] pre_cnt;
  logic [4:0]      pos;
  logic [11:0]     hdr_q;
  hdr_t            hdr_nx;
  logic [15:0]     sh;
  logic            act_rd, act_wr;
  logic [4:0]      ra_q;
  logic            oe_q, do_q;

  logic in_body, dec_now, hit, wr_hit;

  assign hdr_nx  = hdr_t'({hdr_q[10:0], bit_in});
  assign in_body = bit_rise && (phase == PH_BODY);
  assign dec_now = in_body && (pos == FP_REG_LAST);
  assign hit     = (hdr_nx.phy == my_addr) && (hdr_nx.ra < RA_COUNT);
  assign rd_req  = dec_now && hit && (hdr_nx.op == OP_RD);
  assign wr_hit  = dec_now && hit && (hdr_nx.op == OP_WR);

  assign reg_addr = dec_now ? hdr_nx.ra : ra_q;
  assign wr_en    = in_body && (pos == FP_LAST) && act_wr;
  assign wr_data  = {sh[14:0], bit_in};
  assign drv_oe   = oe_q;
  assign drv_bit  = do_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase   <= PH_HUNT;
      pre_cnt <= '0;
      pos     <= '0;
      hdr_q   <= '0;
      sh      <= '0;
      act_rd  <= 1'b0;
      act_wr  <= 1'b0;
      ra_q    <= '0;
      oe_q    <= 1'b0;
      do_q    <= 1'b0;
    end else if (bit_rise) begin
      unique case (phase)
        PH_HUNT: begin
          if (bit_in) begin
            if (pre_cnt != PRE_FULL) pre_cnt <= pre_cnt + 1'b1;
          end else if (pre_cnt == PRE_FULL) begin
            phase   <= PH_START;
            pre_cnt <= '0;
          end else begin
            pre_cnt <= '0;
          end
        end
        PH_START: begin
          pre_cnt <= '0;
          pos     <= '0;
          phase   <= bit_in ? PH_BODY : PH_HUNT;
        end
        PH_BODY: begin
          if (pos <= FP_REG_LAST) hdr_q <= hdr_nx;
          if (pos == FP_REG_LAST) begin
            act_rd <= rd_req;
            act_wr <= wr_hit;
            ra_q   <= hdr_nx.ra;
            if (rd_req) sh <= rd_data;
          end
          if ((pos == FP_TA1) && act_rd) begin
            oe_q <= 1'b1;
            do_q <= 1'b0;
          end
          if ((pos >= FP_TA2) && (pos <= FP_DATA_LST) && act_rd) begin
            do_q <= sh[15];
            sh   <= {sh[14:0], 1'b0};
          end
          if ((pos > FP_TA2) && (pos < FP_LAST) && act_wr)
            sh <= {sh[14:0], bit_in};
          if (pos == FP_LAST) begin
            oe_q   <= 1'b0;
            do_q   <= 1'b0;
            act_rd <= 1'b0;
            act_wr <= 1'b0;
            pos    <= '0;
            phase  <= PH_HUNT;
          end else begin
            pos <= pos + 1'b1;
          end
        end
        default: phase <= PH_HUNT;
      endcase
    end
  end

endmodule

// File: rtl/mdio_reg_bank.sv
module mdio_reg_bank
  import mdio_slv_pkg::*;
#(
  parameter int                        STAT_W  = 8,
  parameter logic [CFG_WORDS*REG_W-1:0] CFG_RST = '0,
  parameter logic [REG_W-1:0]           ID_HI   = 16'h0A5C,
  parameter logic [REG_W-1:0]           ID_LO   = 16'h31E2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [4:0]                  strap_addr,
  input  logic [STAT_W-1:0]           status_in,
  input  logic                        rd_req,
  input  logic                        wr_en,
  input  logic [4:0]                  addr,
  input  logic [REG_W-1:0]            wr_data,
  output logic [REG_W-1:0]            rd_data,
  output logic [4:0]                  phy_addr,
  output logic [CFG_WORDS*REG_W-1:0]  cfg_words,
  output logic                        irq_drive_low
);

  logic [REG_W-1:0]  mask_q;
  logic [STAT_W-1:0] prev_q;
  logic [STAT_W-1:0] latch_q;
  logic [STAT_W-1:0] chg, clr;
  logic [REG_W-1:0]  stat_ext, latch_ext;

  // configuration words, one register per word
  for (genvar k = 0; k < CFG_WORDS; k++) begin : g_cfg
    always_ff @(posedge clk) begin
      if (!rst_n)
        cfg_words[k*REG_W +: REG_W] <= CFG_RST[k*REG_W +: REG_W];
      else if (wr_en && (addr == 5'(k)))
        cfg_words[k*REG_W +: REG_W] <= wr_data;
    end
  end

  // strap capture and mask
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phy_addr <= strap_addr;
      mask_q   <= '1;
    end else if (wr_en && (addr == RA_MASK)) begin
      mask_q <= wr_data;
    end
  end

  // change tracking
  assign chg = (status_in ^ prev_q) & mask_q[STAT_W-1:0];
  assign clr = (rd_req && (addr == RA_CHG)) ? latch_q : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_q  <= status_in;
      latch_q <= '0;
    end else begin
      prev_q  <= status_in;
      latch_q <= (latch_q & ~clr) | chg;
    end
  end

  assign irq_drive_low = |latch_q;

  always_comb begin
    stat_ext                = '0;
    stat_ext[STAT_W-1:0]    = status_in;
    latch_ext               = '0;
    latch_ext[STAT_W-1:0]   = latch_q;
  end

  always_comb begin
    rd_data = '0;
    if (addr < 5'(CFG_WORDS)) begin
      rd_data = cfg_words[addr*REG_W +: REG_W];
    end else begin
      unique case (addr)
        RA_ID_HI: rd_data = ID_HI;
        RA_ID_LO: rd_data = ID_LO;
        RA_STAT:  rd_data = stat_ext;
        RA_CHG:   rd_data = latch_ext;
        RA_MASK:  rd_data = mask_q;
        RA_ADDR:  rd_data = {11'd0, phy_addr};
        default:  rd_data = '0;
      endcase
    end
  end

endmodule

// File: rtl/mdio_mgmt_slave.sv
module mdio_mgmt_slave
  import mdio_slv_pkg::*;
#(
  parameter int                         STAT_W      = 8,
  parameter int                         PRE_LEN     = 32,
  parameter int                         SYNC_STAGES = 2,
  parameter logic [CFG_WORDS*REG_W-1:0] CFG_RST     = 80'h0000_0000_01E1_0000_1000,
  parameter logic [REG_W-1:0]           ID_HI       = 16'h0A5C,
  parameter logic [REG_W-1:0]           ID_LO       = 16'h31E2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [4:0]                 strap_addr,
  input  logic                       mdc,
  input  logic                       mdio_in,
  output logic                       mdio_out,
  output logic                       mdio_oe,
  input  logic [STAT_W-1:0]          status_in,
  output logic                       irq_drive_low,
  output logic [CFG_WORDS*REG_W-1:0] cfg_words
);

  logic              mdc_rise;
  logic              bit_val;
  logic              rd_req;
  logic              wr_en;
  logic [4:0]        rd_addr;
  logic [REG_W-1:0]  wr_data;
  logic [REG_W-1:0]  rd_data;
  logic [4:0]        phy_addr;

  mdio_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc      (mdc),
    .mdio_in  (mdio_in),
    .bit_rise (mdc_rise),
    .bit_val  (bit_val)
  );

  mdio_frame_engine #(
    .PRE_LEN (PRE_LEN)
  ) u_eng (
    .clk      (clk),
    .rst_n    (rst_n),
    .bit_rise (mdc_rise),
    .bit_in   (bit_val),
    .my_addr  (phy_addr),
    .rd_data  (rd_data),
    .rd_req   (rd_req),
    .wr_en    (wr_en),
    .reg_addr (rd_addr),
    .wr_data  (wr_data),
    .drv_oe   (mdio_oe),
    .drv_bit  (mdio_out)
  );

  mdio_reg_bank #(
    .STAT_W  (STAT_W),
    .CFG_RST (CFG_RST),
    .ID_HI   (ID_HI),
    .ID_LO   (ID_LO)
  ) u_bank (
    .clk           (clk),
    .rst_n         (rst_n),
    .strap_addr    (strap_addr),
    .status_in     (status_in),
    .rd_req        (rd_req),
    .wr_en         (wr_en),
    .addr          (rd_addr),
    .wr_data       (wr_data),
    .rd_data       (rd_data),
    .phy_addr      (phy_addr),
    .cfg_words     (cfg_words),
    .irq_drive_low (irq_drive_low)
  );

endmodule

// File: rtl/mdio_mgmt_slave_chk.sv
module mdio_mgmt_slave_chk
  import mdio_slv_pkg::*;
#(
  parameter int STAT_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mdc_rise,
  input logic              mdio_oe,
  input logic              mdio_out,
  input logic              irq_drive_low,
  input logic              rd_req,
  input logic [4:0]        rd_addr,
  input logic              wr_en,
  input logic [4:0]        phy_addr,
  input logic [STAT_W-1:0] status_in
);

  // R3: the first driven bit of a read is the 0 turnaround bit
  assert_ta_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mdio_oe) |-> (mdio_out == 1'b0));

  // R3: the drive enable only moves right after a management clock rise
  assert_oe_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(mdc_rise) |-> $stable(mdio_oe));

  // R1: the strapped address never moves once reset is released
  assert_addr_held_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> $stable(phy_addr));

  // R4: a register write never coincides with the block driving the line
  assert_no_drive_on_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !mdio_oe);

  // R7: the interrupt rises only after a status input moved
  assert_irq_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_drive_low) |-> ($past(status_in) != $past(status_in, 2)));

  // R8: the interrupt only drops after a read of the change latch
  assert_irq_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq_drive_low) |-> $past(rd_req && (rd_addr == RA_CHG)));

endmodule

bind mdio_mgmt_slave mdio_mgmt_slave_chk #(
  .STAT_W (STAT_W)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .mdc_rise      (mdc_rise),
  .mdio_oe       (mdio_oe),
  .mdio_out      (mdio_out),
  .irq_drive_low (irq_drive_low),
  .rd_req        (rd_req),
  .rd_addr       (rd_addr),
  .wr_en         (wr_en),
  .phy_addr      (phy_addr),
  .status_in     (status_in)
);

// File: tb/mdio_mgmt_slave_test.sv
`timescale 1ns/1ps
module mdio_mgmt_slave_test;

  localparam int          STAT_W = 8;
  localparam logic [79:0] CFG_R  = 80'h0000_0000_01E1_0000_1000;
  localparam logic [15:0] IDH    = 16'h0A5C;
  localparam logic [15:0] IDL    = 16'h31E2;
  localparam int          HALF   = 8;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [4:0]        strap_addr = 5'h13;
  logic              mdc = 1'b0;
  logic              m_en = 1'b0;
  logic              m_val = 1'b1;
  logic              line;
  logic              mdio_out, mdio_oe, irq_drive_low;
  logic [STAT_W-1:0] status_in = '0;
  logic [79:0]       cfg_words;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model
  logic [15:0]       cfg_m [5];
  logic [15:0]       mask_m;
  logic [STAT_W-1:0] latch_m;
  logic [STAT_W-1:0] stat_m;
  logic [4:0]        addr_m;

  always #2.5 clk = ~clk;

  assign line = m_en ? m_val : (mdio_oe ? mdio_out : 1'b1);

  mdio_mgmt_slave #(
    .STAT_W (STAT_W), .PRE_LEN (32), .SYNC_STAGES (2),
    .CFG_RST (CFG_R), .ID_HI (IDH), .ID_LO (IDL)
  ) uut (
    .clk (clk), .rst_n (rst_n), .strap_addr (strap_addr),
    .mdc (mdc), .mdio_in (line), .mdio_out (mdio_out), .mdio_oe (mdio_oe),
    .status_in (status_in), .irq_drive_low (irq_drive_low), .cfg_words (cfg_words)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] model_read(input logic [4:0] a);
    logic [15:0] v;
    v = '0;
    if (a < 5) v = cfg_m[a];
    else if (a == 5) v = IDH;
    else if (a == 6) v = IDL;
    else if (a == 7) v[STAT_W-1:0] = stat_m;
    else if (a == 8) v[STAT_W-1:0] = latch_m;
    else if (a == 9) v = mask_m;
    else if (a == 10) v = {11'd0, addr_m};
    return v;
  endfunction

  task automatic mbit(input logic drv, input logic val, output logic smp, output logic oe_s);
    m_en  = drv;
    m_val = val;
    repeat (HALF) @(negedge clk);
    smp  = line;
    oe_s = mdio_oe;
    mdc  = 1'b1;
    repeat (HALF) @(negedge clk);
    mdc  = 1'b0;
  endtask

  task automatic run_frame(input int pre, input logic [1:0] op, input logic [4:0] phy,
                           input logic [4:0] ra, input logic [15:0] wd,
                           output logic [15:0] rd, output logic ta1_oe,
                           output logic ta2_oe, output logic ta2_v, output int drv);
    logic s, o;
    rd = '0; drv = 0;
    for (int i = 0; i < pre; i++) mbit(1'b1, 1'b1, s, o);
    mbit(1'b1, 1'b0, s, o);
    mbit(1'b1, 1'b1, s, o);
    for (int i = 1; i >= 0; i--) mbit(1'b1, op[i], s, o);
    for (int i = 4; i >= 0; i--) mbit(1'b1, phy[i], s, o);
    for (int i = 4; i >= 0; i--) mbit(1'b1, ra[i], s, o);
    if (op == 2'b10) begin
      mbit(1'b0, 1'b0, s, o); ta1_oe = o;
      mbit(1'b0, 1'b0, s, o); ta2_oe = o; ta2_v = s;
      for (int i = 15; i >= 0; i--) begin
        mbit(1'b0, 1'b0, s, o);
        rd[i] = s;
        drv += int'(o);
      end
    end else begin
      mbit(1'b1, 1'b1, s, o); ta1_oe = o;
      mbit(1'b1, 1'b0, s, o); ta2_oe = o; ta2_v = s;
      for (int i = 15; i >= 0; i--) begin
        mbit(1'b1, wd[i], s, o);
        drv += int'(o);
      end
    end
    m_en = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic do_read(input logic [4:0] phy, input logic [4:0] ra, input string tag);
    logic [15:0] rd, expv;
    logic t1, t2, tv;
    int drv;
    bit acts;
    acts = (phy == addr_m) && (ra < 11);
    expv = model_read(ra);
    run_frame(32, 2'b10, phy, ra, 16'h0, rd, t1, t2, tv, drv);
    if (acts) begin
      chk(!t1, {tag, " R3 first turnaround released"}, t1, 0);
      chk(t2 && !tv, {tag, " R3 second turnaround driven 0"}, {t2, tv}, 2'b10);
      chk(rd == expv, {tag, " read data"}, rd, expv);
      if (ra == 8) latch_m = '0;
    end else begin
      chk(drv == 0 && !t2, {tag, " ignored read leaves line released"}, drv, 0);
    end
    chk(!mdio_oe, {tag, " R3 line released after frame"}, mdio_oe, 0);
  endtask

  task automatic do_write(input int pre, input logic [1:0] op, input logic [4:0] phy,
                          input logic [4:0] ra, input logic [15:0] d, input string tag);
    logic [15:0] rd;
    logic t1, t2, tv;
    int drv;
    logic [79:0] expc;
    run_frame(pre, op, phy, ra, d, rd, t1, t2, tv, drv);
    if (pre >= 32 && op == 2'b01 && phy == addr_m) begin
      if (ra < 5) cfg_m[ra] = d;
      else if (ra == 9) mask_m = d;
    end
    expc = {cfg_m[4], cfg_m[3], cfg_m[2], cfg_m[1], cfg_m[0]};
    chk(cfg_words == expc, {tag, " cfg_words after write"}, cfg_words[31:0], expc[31:0]);
    chk(drv == 0, {tag, " no drive during write frame"}, drv, 0);
  endtask

  task automatic set_status(input logic [STAT_W-1:0] nv, input string tag);
    latch_m   = latch_m | ((stat_m ^ nv) & mask_m[STAT_W-1:0]);
    stat_m    = nv;
    status_in = nv;
    repeat (4) @(negedge clk);
    chk(irq_drive_low == (latch_m != 0), {tag, " irq follows change latch"}, irq_drive_low, latch_m != 0);
  endtask

  initial begin
    logic [4:0] other;
    int unsigned seed;
    seed = $urandom(32'h5EED);
    for (int k = 0; k < 5; k++) cfg_m[k] = CFG_R[k*16 +: 16];
    mask_m = 16'hFFFF; latch_m = '0; stat_m = '0; addr_m = 5'h13;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    chk(!mdio_oe, "R11 line released at reset", mdio_oe, 0);
    chk(!irq_drive_low, "R11 irq idle at reset", irq_drive_low, 0);
    chk(cfg_words == CFG_R, "R11 cfg reset value", cfg_words[31:0], CFG_R[31:0]);

    // R1 strap readback, later strap changes ignored
    strap_addr = 5'h04;
    do_read(5'h13, 5'd10, "R1 strap readback");
    do_read(5'h04, 5'd10, "R1 new strap value ignored");
    do_write(32, 2'b01, 5'h04, 5'd0, 16'h1111, "R1 other address write");

    // R6 identifier and status
    do_read(5'h13, 5'd5, "R6 id hi");
    do_read(5'h13, 5'd6, "R6 id lo");

    // R4 writes and read-only protection
    do_write(32, 2'b01, 5'h13, 5'd0, 16'hBEEF, "R4 cfg0");
    do_read(5'h13, 5'd0, "R4 cfg0 readback");
    do_write(32, 2'b01, 5'h13, 5'd4, 16'h8001, "R4 cfg4");
    do_write(32, 2'b01, 5'h13, 5'd5, 16'h0000, "R4 read-only id");
    do_read(5'h13, 5'd5, "R4 id unchanged");
    do_write(32, 2'b01, 5'h13, 5'd10, 16'h001F, "R4 read-only addr");
    do_read(5'h13, 5'd10, "R4 addr unchanged");

    // R2 short preamble
    do_write(31, 2'b01, 5'h13, 5'd1, 16'h5A5A, "R2 31-bit preamble");
    do_read(5'h13, 5'd1, "R2 cfg1 untouched");

    // R5 unimplemented registers
    do_read(5'h13, 5'd12, "R5 read reg 12");
    do_read(5'h13, 5'd31, "R5 read reg 31");
    do_write(32, 2'b01, 5'h13, 5'd15, 16'h7777, "R5 write reg 15");

    // R10 illegal opcodes
    do_write(32, 2'b11, 5'h13, 5'd0, 16'h2222, "R10 opcode 11");
    do_write(32, 2'b00, 5'h13, 5'd2, 16'h3333, "R10 opcode 00");

    // R7 / R8 change latch
    set_status(8'h04, "R7 bit2 set");
    set_status(8'h00, "R7 bit2 back, stays latched");
    do_read(5'h13, 5'd7, "R6 live status");
    do_read(5'h13, 5'd8, "R8 latch read");
    chk(!irq_drive_low, "R8 irq cleared after read", irq_drive_low, 0);
    set_status(8'h0A, "R7 bits 1 and 3");
    do_read(5'h13, 5'd8, "R8 second latch read");
    chk(!irq_drive_low, "R8 irq cleared again", irq_drive_low, 0);

    // R9 mask
    do_read(5'h13, 5'd9, "R9 mask reset value");
    do_write(32, 2'b01, 5'h13, 5'd9, 16'h00FE, "R9 mask write");
    set_status(8'h0B, "R9 masked bit0 toggle");
    chk(!irq_drive_low, "R9 masked change no irq", irq_drive_low, 0);
    do_read(5'h13, 5'd8, "R9 latch empty");
    set_status(8'h8B, "R9 unmasked bit7");
    do_read(5'h13, 5'd8, "R8 latch bit7");

    // random mix
    for (int n = 0; n < 60; n++) begin
      int r;
      logic [4:0] phy, ra;
      logic [1:0] op;
      if ($urandom % 3 == 0) set_status(STAT_W'($urandom), "R7 random status");
      other = 5'h13 ^ 5'(1 + ($urandom % 31));
      phy = ($urandom % 4 == 0) ? other : 5'h13;
      ra  = 5'($urandom % 16);
      r   = int'($urandom % 8);
      op  = (r == 0) ? (($urandom % 2) ? 2'b11 : 2'b00) : (r < 4) ? 2'b01 : 2'b10;
      if (op == 2'b10) do_read(phy, ra, "R3 random read");
      else do_write(32, op, phy, ra, 16'($urandom), "R4 random write");
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R3 actual=hung expected=complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule